// File: doc/BRIEF.md
# Dual-Core Trace Port Packer

This block lets two processor trace units share one 20-bit trace data bus. Both trace units run from the same trace clock. Each unit presents three fields:

- a 16-bit packet field,
- a 3-bit pipeline status,
- a 1-bit sync flag.

Each unit also presents a 5-bit port-size code. The block compares the two size codes and picks a division of the pins. Either one core drives all 20 pins, or the bus is split into a 12-pin part and an 8-pin part, one part per core. The block then packs each core's fields into its part of the bus and registers the result.

Each slice is packed from its top bit downward: pipeline status first, then the sync flag, then the low packet bits. A 2-bit mode output reports which division was applied. A one-bit flag marks any size-code pair that falls outside the supported set. For such a pair the block falls back to core A driving the whole bus.

Trace data cannot be held back, so the data path has no handshake. A new word is produced on every clock and there is no back-pressure.

Top module: `trace_port_packer`

## Requirements
- R1: While the synchronous active-high reset is high, the next clock edge clears `trace_data`, `mode` and `cfg_err` to zero.
- R2: Every output is registered. The values present at the inputs on one rising edge appear at the outputs after that edge, and a size-code change takes effect at the next edge.
- R3: When `b_size` equals 21, `trace_data` carries `{b_stat, b_sync, b_pkt[15:0]}`, with the status in bits 19:17 and the sync flag in bit 16. `mode` is 3 and `cfg_err` is 0, whatever `a_size` holds.
- R4: When `a_size` is 13 and `b_size` is 9, bits 19:12 carry `{b_stat, b_sync, b_pkt[3:0]}` and bits 11:0 carry `{a_stat, a_sync, a_pkt[7:0]}`. `mode` is 1 and `cfg_err` is 0.
- R5: When `a_size` is 9 and `b_size` is 13, bits 19:12 carry `{a_stat, a_sync, a_pkt[3:0]}` and bits 11:0 carry `{b_stat, b_sync, b_pkt[7:0]}`. `mode` is 2 and `cfg_err` is 0.
- R6: When `a_size` is 21 and `b_size` is not 21, `trace_data` carries `{a_stat, a_sync, a_pkt[15:0]}`. `mode` is 0 and `cfg_err` is 0.
- R7: Every other pair of size codes gives the same `trace_data` as R6 and `mode` 0, with `cfg_err` set to 1. Size codes are compared over all 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared trace clock |
| rst | input | 1 | Synchronous reset, active high |
| a_pkt | input | 16 | Core A packet field |
| a_stat | input | 3 | Core A pipeline status |
| a_sync | input | 1 | Core A sync flag |
| a_size | input | 5 | Core A port-size code |
| b_pkt | input | 16 | Core B packet field |
| b_stat | input | 3 | Core B pipeline status |
| b_sync | input | 1 | Core B sync flag |
| b_size | input | 5 | Core B port-size code |
| trace_data | output | 20 | Packed trace bus |
| mode | output | 2 | Division applied: 0 A full, 1 A12/B8, 2 A8/B12, 3 B full |
| cfg_err | output | 1 | Size-code pair is not supported |

## Verification
The assertions assume the inputs are settled at each rising edge and never X. They also assume the reset is held for at least one edge before the first compare.

The bench meets these assumptions by changing every input one time unit after a rising edge and by starting the run in reset. It then sweeps all 1024 pairs of size codes, with new packet, status and sync values on every cycle. This exercises each division, the fallback, and a configuration change on every clock.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  typedef enum logic [1:0] {
    SPLIT_A_FULL = 2'd0,
    SPLIT_A12_B8 = 2'd1,
    SPLIT_A8_B12 = 2'd2,
    SPLIT_B_FULL = 2'd3
  } split_e;
endpackage

// File: rtl/tpp_size_decode.sv
module tpp_size_decode
  import tpp_pkg::*;
#(
  parameter int SIZE_W     = 5,
  parameter int CODE_FULL  = 21,
  parameter int CODE_WIDE  = 13,
  parameter int CODE_SMALL = 9
) (
  input  logic [SIZE_W-1:0] size_a,
  input  logic [SIZE_W-1:0] size_b,
  output split_e            split,
  output logic              bad_pair
);
  localparam logic [SIZE_W-1:0] K_FULL  = SIZE_W'(CODE_FULL);
  localparam logic [SIZE_W-1:0] K_WIDE  = SIZE_W'(CODE_WIDE);
  localparam logic [SIZE_W-1:0] K_SMALL = SIZE_W'(CODE_SMALL);

  logic b_full, a_full, a12b8, a8b12;

  always_comb begin
    b_full = (size_b == K_FULL);
    a_full = (size_a == K_FULL);
    a12b8  = (size_a == K_WIDE)  && (size_b == K_SMALL);
    a8b12  = (size_a == K_SMALL) && (size_b == K_WIDE);
    // core B full width wins over everything else
    if (b_full)     split = SPLIT_B_FULL;
    else if (a12b8) split = SPLIT_A12_B8;
    else if (a8b12) split = SPLIT_A8_B12;
    else            split = SPLIT_A_FULL;
    bad_pair = !(b_full || a_full || a12b8 || a8b12);
  end
endmodule

// File: rtl/tpp_slice.sv
module tpp_slice #(
  parameter int STAT_W = 3,
  parameter int PKT_W  = 16,
  parameter int KEEP   = 16,
  localparam int OUT_W = STAT_W + 1 + KEEP
) (
  input  logic [STAT_W-1:0] stat,
  input  logic              sync,
  input  logic [PKT_W-1:0]  pkt,
  output logic [OUT_W-1:0]  slice
);
  assign slice = {stat, sync, pkt[KEEP-1:0]};
endmodule

// File: rtl/tpp_bus_mux.sv
module tpp_bus_mux
  import tpp_pkg::*;
#(
  parameter int FULL_W  = 20,
  parameter int WIDE_W  = 12,
  parameter int SMALL_W = 8
) (
  input  split_e             split,
  input  logic [FULL_W-1:0]  a_full,
  input  logic [WIDE_W-1:0]  a_wide,
  input  logic [SMALL_W-1:0] a_small,
  input  logic [FULL_W-1:0]  b_full,
  input  logic [WIDE_W-1:0]  b_wide,
  input  logic [SMALL_W-1:0] b_small,
  output logic [FULL_W-1:0]  bus
);
  always_comb begin
    unique case (split)
      SPLIT_B_FULL: bus = b_full;
      SPLIT_A12_B8: bus = {b_small, a_wide};
      SPLIT_A8_B12: bus = {a_small, b_wide};
      default:      bus = a_full;
    endcase
  end
endmodule

// File: rtl/trace_port_packer.sv
module trace_port_packer
  import tpp_pkg::*;
#(
  parameter int PKT_W      = 16,
  parameter int STAT_W     = 3,
  parameter int WIDE_PKT   = 8,
  parameter int SMALL_PKT  = 4,
  parameter int SIZE_W     = 5,
  parameter int CODE_FULL  = 21,
  parameter int CODE_WIDE  = 13,
  parameter int CODE_SMALL = 9,
  localparam int BUS_W     = STAT_W + 1 + PKT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PKT_W-1:0]  a_pkt,
  input  logic [STAT_W-1:0] a_stat,
  input  logic              a_sync,
  input  logic [SIZE_W-1:0] a_size,
  input  logic [PKT_W-1:0]  b_pkt,
  input  logic [STAT_W-1:0] b_stat,
  input  logic              b_sync,
  input  logic [SIZE_W-1:0] b_size,
  output logic [BUS_W-1:0]  trace_data,
  output logic [1:0]        mode,
  output logic              cfg_err
);
  localparam int WIDE_W  = STAT_W + 1 + WIDE_PKT;
  localparam int SMALL_W = STAT_W + 1 + SMALL_PKT;
  localparam logic [SIZE_W-1:0] K_FULL  = SIZE_W'(CODE_FULL);
  localparam logic [SIZE_W-1:0] K_WIDE  = SIZE_W'(CODE_WIDE);
  localparam logic [SIZE_W-1:0] K_SMALL = SIZE_W'(CODE_SMALL);

  logic [PKT_W-1:0]   pkt_c  [2];
  logic [STAT_W-1:0]  stat_c [2];
  logic               sync_c [2];
  logic [BUS_W-1:0]   full_s [2];
  logic [WIDE_W-1:0]  wide_s [2];
  logic [SMALL_W-1:0] small_s[2];

  assign pkt_c[0]  = a_pkt;
  assign pkt_c[1]  = b_pkt;
  assign stat_c[0] = a_stat;
  assign stat_c[1] = b_stat;
  assign sync_c[0] = a_sync;
  assign sync_c[1] = b_sync;

  for (genvar c = 0; c < 2; c++) begin : g_core
    tpp_slice #(.STAT_W(STAT_W), .PKT_W(PKT_W), .KEEP(PKT_W)) u_full (
      .stat(stat_c[c]), .sync(sync_c[c]), .pkt(pkt_c[c]), .slice(full_s[c]));
    tpp_slice #(.STAT_W(STAT_W), .PKT_W(PKT_W), .KEEP(WIDE_PKT)) u_wide (
      .stat(stat_c[c]), .sync(sync_c[c]), .pkt(pkt_c[c]), .slice(wide_s[c]));
    tpp_slice #(.STAT_W(STAT_W), .PKT_W(PKT_W), .KEEP(SMALL_PKT)) u_small (
      .stat(stat_c[c]), .sync(sync_c[c]), .pkt(pkt_c[c]), .slice(small_s[c]));
  end

  split_e           split_nxt;
  logic             bad_nxt;
  logic [BUS_W-1:0] bus_nxt;

  tpp_size_decode #(
    .SIZE_W(SIZE_W), .CODE_FULL(CODE_FULL),
    .CODE_WIDE(CODE_WIDE), .CODE_SMALL(CODE_SMALL)
  ) u_dec (
    .size_a(a_size), .size_b(b_size), .split(split_nxt), .bad_pair(bad_nxt));

  tpp_bus_mux #(.FULL_W(BUS_W), .WIDE_W(WIDE_W), .SMALL_W(SMALL_W)) u_mux (
    .split(split_nxt),
    .a_full(full_s[0]), .a_wide(wide_s[0]), .a_small(small_s[0]),
    .b_full(full_s[1]), .b_wide(wide_s[1]), .b_small(small_s[1]),
    .bus(bus_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      trace_data <= '0;
      mode       <= 2'd0;
      cfg_err    <= 1'b0;
    end else begin
      trace_data <= bus_nxt;
      mode       <= split_nxt;
      cfg_err    <= bad_nxt;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (trace_data == '0 && mode == 2'd0 && !cfg_err));

  // R3
  b_full_chk: assert property (@(posedge clk) disable iff (rst)
    (b_size == K_FULL) |=> (mode == 2'd3 && !cfg_err &&
      trace_data == {$past(b_stat), $past(b_sync), $past(b_pkt)}));

  // R4
  a12_b8_chk: assert property (@(posedge clk) disable iff (rst)
    (a_size == K_WIDE && b_size == K_SMALL) |=> (mode == 2'd1 && !cfg_err));

  // R5
  a8_b12_chk: assert property (@(posedge clk) disable iff (rst)
    (a_size == K_SMALL && b_size == K_WIDE) |=> (mode == 2'd2 && !cfg_err));

  // R7
  err_mode_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (mode == 2'd0));

  // R6
  a_full_chk: assert property (@(posedge clk) disable iff (rst)
    (a_size == K_FULL && b_size != K_FULL) |=> (mode == 2'd0 && !cfg_err &&
      trace_data == {$past(a_stat), $past(a_sync), $past(a_pkt)}));
endmodule

// File: tb/trace_port_packer_tb_top.sv
`timescale 1ns/1ps
module trace_port_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_pkt = '0, b_pkt = '0;
  logic [2:0]  a_stat = '0, b_stat = '0;
  logic        a_sync = 1'b0, b_sync = 1'b0;
  logic [4:0]  a_size = '0, b_size = '0;
  logic [19:0] trace_data;
  logic [1:0]  mode;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  trace_port_packer dut_i (
    .clk(clk), .rst(rst),
    .a_pkt(a_pkt), .a_stat(a_stat), .a_sync(a_sync), .a_size(a_size),
    .b_pkt(b_pkt), .b_stat(b_stat), .b_sync(b_sync), .b_size(b_size),
    .trace_data(trace_data), .mode(mode), .cfg_err(cfg_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
  endtask

  task automatic drive_data();
    step_rand();
    a_pkt  = lfsr[15:0];
    b_pkt  = lfsr[31:16];
    step_rand();
    a_stat = lfsr[2:0];
    b_stat = lfsr[5:3];
    a_sync = lfsr[6];
    b_sync = lfsr[7];
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int exp_bus, exp_mode, exp_err;
    string tag;
    a_size = 5'd21;
    b_size = 5'd21;
    drive_data();
    repeat (2) @(posedge clk);
    #1;
    // R1: reset clears everything
    check("R1 data", 32'(trace_data), 32'd0);
    check("R1 mode", 32'(mode), 32'd0);
    check("R1 err", 32'(cfg_err), 32'd0);
    rst = 1'b0;

    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        a_size = 5'(a);
        b_size = 5'(b);
        drive_data();
        if (b == 21) begin
          tag = "R3";
          exp_mode = 3;
          exp_err = 0;
          exp_bus = (int'(b_stat) << 17) | (int'(b_sync) << 16) | int'(b_pkt);
        end else if (a == 13 && b == 9) begin
          tag = "R4";
          exp_mode = 1;
          exp_err = 0;
          exp_bus = (int'(b_stat) << 17) | (int'(b_sync) << 16) | ((int'(b_pkt) % 16) << 12)
                  | (int'(a_stat) << 9) | (int'(a_sync) << 8) | (int'(a_pkt) % 256);
        end else if (a == 9 && b == 13) begin
          tag = "R5";
          exp_mode = 2;
          exp_err = 0;
          exp_bus = (int'(a_stat) << 17) | (int'(a_sync) << 16) | ((int'(a_pkt) % 16) << 12)
                  | (int'(b_stat) << 9) | (int'(b_sync) << 8) | (int'(b_pkt) % 256);
        end else begin
          tag = (a == 21) ? "R6" : "R7";
          exp_mode = 0;
          exp_err = (a == 21) ? 0 : 1;
          exp_bus = (int'(a_stat) << 17) | (int'(a_sync) << 16) | int'(a_pkt);
        end
        @(posedge clk);
        #1;
        // R2: one-edge latency, config follows every cycle
        check({tag, " R2 data"}, 32'(trace_data), 32'(exp_bus));
        check({tag, " mode"}, 32'(mode), 32'(exp_mode));
        check({tag, " err"}, 32'(cfg_err), 32'(exp_err));
      end
    end

    // R1: reset in mid-run from a faulty configuration
    a_size = 5'd3;
    b_size = 5'd4;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid data", 32'(trace_data), 32'd0);
    check("R1 mid err", 32'(cfg_err), 32'd0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R7 after reset", 32'(cfg_err), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule